// File: doc/BRIEF.md
# Multi-Size Logical Left Shifter

This block is the left-shift execution unit of a CPU datapath. Each operation takes a 32-bit source register value, an operand size (byte, word or long), and a shift count. The count is either a small immediate or an 8-bit value read from another register. The block returns the 32-bit value to write back and a fresh set of condition flags. Only the low bits that belong to the selected size are shifted. The bits above that size are returned exactly as they arrived, so the caller can write the whole register back without a separate merge step.

The unit registers its result, which appears one clock after the operation is offered. Parameter `EXT_MODE` chooses the instruction subset. With `EXT_MODE = 0`, only immediate counts of one and two are accepted. With `EXT_MODE = 1`, wider immediate counts and register-supplied counts are also accepted. When an operation is not legal under the current mode and size, the block flags it as illegal and returns the source value and incoming flags unchanged.

Flags are packed into a five-bit vector. Bit 4 is H (half carry), bit 3 is N (negative), bit 2 is Z (zero), bit 1 is V (overflow) and bit 0 is C (carry). The size code is 0 for byte (bits 7:0), 1 for word (bits 15:0) and 2 for long (bits 31:0). Code 3 is reserved.

Top module: `shl_unit`

## Requirements
- R1: A byte operation leaves bits 31:8 of the returned value equal to the source, and a word operation leaves bits 31:16 equal to the source.
- R2: Within the selected size, the result is the operand shifted left by the count, with zeros entering at the low end (byte 0xa5 by 4 gives 0x50).
- R3: C is the last bit shifted out of the operand at the selected size. C is 0 when the count is zero, so for example word 0xa5a5 by 8 gives C=1.
- R4: N is the most significant bit of the result at the selected size. Z is 1 exactly when that sized result is zero.
- R5: On every legal operation, H and V are returned as 0, whatever their incoming values.
- R6: An immediate count of 1 or 2 is legal in both modes. In extended mode, 4 is also legal for every size, 8 is legal for word and long, and 16 is legal for long only. Every other immediate count is illegal.
- R7: A register-supplied count is legal only in extended mode, and it uses all 8 bits of the count value. A count equal to the operand width gives a zero result with C equal to the operand's LSB. A larger count gives zero with C=0.
- R8: An illegal operation sets `res_illegal`, returns the source value unchanged and returns `cur_flags` unchanged. Size code 3 is always illegal.
- R9: `res_valid` rises exactly one clock after `op_valid`. Synchronous reset clears `res_valid`, `res_val`, `res_flags` and `res_illegal` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 long, 3 reserved |
| cnt_from_reg | input | 1 | 1: take the count from `reg_cnt`; 0: take it from `imm_cnt` |
| imm_cnt | input | 5 | Immediate shift count |
| reg_cnt | input | 8 | Register-supplied shift count |
| src_val | input | 32 | Source register value |
| cur_flags | input | 5 | Current flags {H,N,Z,V,C}, returned on an illegal operation |
| res_valid | output | 1 | Result valid |
| res_val | output | 32 | Value to write back |
| res_flags | output | 5 | New flags {H,N,Z,V,C} |
| res_illegal | output | 1 | Operation was not legal in this mode and size |

## Verification
The in-RTL assertions hold on every cycle for the following behaviours:
- the one-cycle valid latency;
- the clearing of H and V on legal results;
- the pass-through of value and flags on illegal operations;
- the preservation of the upper bits for byte and word operations;
- agreement between Z and N and the sized result;
- the restriction of the basic mode to counts of one and two.

The shifted values themselves, and the carry chosen at each size, can only be shown by the bench's directed scenarios. The same applies to the behaviour at counts of zero, at the operand width and beyond it, and to the exact legality table in each mode.

// File: rtl/shl_pkg.sv
package shl_pkg;

    localparam int REG_W  = 32;
    localparam int CNT_W  = 8;
    localparam int IMM_W  = 5;
    localparam int N_LANE = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } opsize_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic [REG_W-1:0] val;
        ccr_t             flags;
        logic             illegal;
    } shres_t;

    // Width in bits of a lane index (0 -> 8, 1 -> 16, 2 -> 32)
    function automatic int lane_bits(input int idx);
        return 8 << idx;
    endfunction

    // Legality of an immediate count for a mode and operand size
    function automatic logic imm_ok(input logic ext, input opsize_e sz,
                                    input logic [IMM_W-1:0] k);
        logic basic_k;
        logic wide_k;
        basic_k = (k == 5'd1) || (k == 5'd2);
        wide_k  = (k == 5'd4)
               || ((k == 5'd8)  && (sz != SZ_BYTE))
               || ((k == 5'd16) && (sz == SZ_LONG));
        return (sz != SZ_RSVD) && (basic_k || (ext && wide_k));
    endfunction

endpackage

// File: rtl/shl_count_sel.sv
module shl_count_sel
    import shl_pkg::*;
#(
    parameter bit EXT_MODE = 1'b1
) (
    input  opsize_e          sz,
    input  logic             from_reg,
    input  logic [IMM_W-1:0] imm_cnt,
    input  logic [CNT_W-1:0] reg_cnt,
    output logic             legal,
    output logic [CNT_W-1:0] amount
);

    generate
        if (EXT_MODE) begin : g_ext
            always_comb begin
                if (from_reg) begin
                    legal  = (sz != SZ_RSVD);
                    amount = reg_cnt;
                end else begin
                    legal  = imm_ok(1'b1, sz, imm_cnt);
                    amount = CNT_W'(imm_cnt);
                end
            end
        end else begin : g_basic
            always_comb begin
                legal  = !from_reg && imm_ok(1'b0, sz, imm_cnt);
                amount = CNT_W'(imm_cnt);
            end
        end
    endgenerate

endmodule

// File: rtl/shl_lanes.sv
module shl_lanes
    import shl_pkg::*;
(
    input  logic [REG_W-1:0] src,
    input  logic [CNT_W-1:0] amount,
    output logic [REG_W-1:0] lane_val [N_LANE],
    output logic             lane_c   [N_LANE]
);

    for (genvar i = 0; i < N_LANE; i++) begin : g_lane
        localparam int W = lane_bits(i);
        logic [W:0] ext_shift;
        always_comb ext_shift = {1'b0, src[W-1:0]} << amount;
        if (W < REG_W) begin : g_part
            assign lane_val[i] = {{(REG_W-W){1'b0}}, ext_shift[W-1:0]};
        end else begin : g_full
            assign lane_val[i] = ext_shift[W-1:0];
        end
        assign lane_c[i] = ext_shift[W];
    end

endmodule

// File: rtl/shl_merge.sv
module shl_merge
    import shl_pkg::*;
(
    input  opsize_e          sz,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] lane_val [N_LANE],
    input  logic             lane_c   [N_LANE],
    output logic [REG_W-1:0] merged,
    output ccr_t             flags
);

    always_comb begin
        merged = src;
        flags  = '0;
        unique case (sz)
            SZ_BYTE: begin
                merged  = {src[REG_W-1:8], lane_val[0][7:0]};
                flags.n = lane_val[0][7];
                flags.z = (lane_val[0][7:0] == 8'h00);
                flags.c = lane_c[0];
            end
            SZ_WORD: begin
                merged  = {src[REG_W-1:16], lane_val[1][15:0]};
                flags.n = lane_val[1][15];
                flags.z = (lane_val[1][15:0] == 16'h0000);
                flags.c = lane_c[1];
            end
            SZ_LONG: begin
                merged  = lane_val[2];
                flags.n = lane_val[2][REG_W-1];
                flags.z = (lane_val[2] == '0);
                flags.c = lane_c[2];
            end
            default: begin
                merged = src;
                flags  = '0;
            end
        endcase
    end

endmodule

// File: rtl/shl_unit.sv
module shl_unit
    import shl_pkg::*;
#(
    parameter bit EXT_MODE = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [1:0]          op_size,
    input  logic                cnt_from_reg,
    input  logic [IMM_W-1:0]    imm_cnt,
    input  logic [CNT_W-1:0]    reg_cnt,
    input  logic [REG_W-1:0]    src_val,
    input  logic [4:0]          cur_flags,
    output logic                res_valid,
    output logic [REG_W-1:0]    res_val,
    output logic [4:0]          res_flags,
    output logic                res_illegal
);

    opsize_e          sz;
    logic             legal;
    logic [CNT_W-1:0] amount;
    logic [REG_W-1:0] lane_val [N_LANE];
    logic             lane_c   [N_LANE];
    logic [REG_W-1:0] merged;
    ccr_t             new_flags;
    shres_t           nxt;
    shres_t           res_q;
    logic             valid_q;

    assign sz = opsize_e'(op_size);

    shl_count_sel #(.EXT_MODE(EXT_MODE)) u_cnt (
        .sz       (sz),
        .from_reg (cnt_from_reg),
        .imm_cnt  (imm_cnt),
        .reg_cnt  (reg_cnt),
        .legal    (legal),
        .amount   (amount)
    );

    shl_lanes u_lanes (
        .src      (src_val),
        .amount   (amount),
        .lane_val (lane_val),
        .lane_c   (lane_c)
    );

    shl_merge u_merge (
        .sz       (sz),
        .src      (src_val),
        .lane_val (lane_val),
        .lane_c   (lane_c),
        .merged   (merged),
        .flags    (new_flags)
    );

    always_comb begin
        if (legal) begin
            nxt.val     = merged;
            nxt.flags   = new_flags;
            nxt.illegal = 1'b0;
        end else begin
            nxt.val     = src_val;
            nxt.flags   = ccr_t'(cur_flags);
            nxt.illegal = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= op_valid;
            if (op_valid) res_q <= nxt;
        end
    end

    assign res_valid   = valid_q;
    assign res_val     = res_q.val;
    assign res_flags   = res_q.flags;
    assign res_illegal = res_q.illegal;

    // R9: result strobe follows the request by one clock
    a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R5: legal results never carry H or V
    a_r5_hv_clear: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_illegal) |-> (res_flags[4] == 1'b0 && res_flags[1] == 1'b0));

    // R8: illegal operations return the source value and the incoming flags
    a_r8_illegal_passthru: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !legal) |=> (res_illegal && res_val == $past(src_val)
                                  && res_flags == $past(cur_flags)));

    // R1: upper bits survive byte and word operations
    a_r1_upper_keep: assert property (@(posedge clk) disable iff (rst)
        (op_valid && sz == SZ_BYTE) |=> (res_val[31:8] == $past(src_val[31:8])));

    a_r1_upper_keep_word: assert property (@(posedge clk) disable iff (rst)
        (op_valid && sz == SZ_WORD) |=> (res_val[31:16] == $past(src_val[31:16])));

    // R4: Z and N agree with the sized result
    a_r4_zn_byte: assert property (@(posedge clk) disable iff (rst)
        (op_valid && legal && sz == SZ_BYTE) |=>
            (res_flags[2] == (res_val[7:0] == 8'h00) && res_flags[3] == res_val[7]));

    a_r4_zn_long: assert property (@(posedge clk) disable iff (rst)
        (op_valid && legal && sz == SZ_LONG) |=>
            (res_flags[2] == (res_val == '0) && res_flags[3] == res_val[31]));

    // R6: the basic subset only shifts by one or two
    a_r6_basic_counts: assert property (@(posedge clk) disable iff (rst)
        (!EXT_MODE && op_valid && legal) |-> (!cnt_from_reg && amount inside {8'd1, 8'd2}));

endmodule

// File: tb/tb_shl_unit.sv
`timescale 1ns/1ps
module tb_shl_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_size;
    logic        cnt_from_reg;
    logic [4:0]  imm_cnt;
    logic [7:0]  reg_cnt;
    logic [31:0] src_val;
    logic [4:0]  cur_flags;
    logic        res_valid,   b_valid;
    logic [31:0] res_val,     b_val;
    logic [4:0]  res_flags,   b_flags;
    logic        res_illegal, b_illegal;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    shl_unit #(.EXT_MODE(1'b1)) dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_size(op_size),
        .cnt_from_reg(cnt_from_reg), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
        .src_val(src_val), .cur_flags(cur_flags),
        .res_valid(res_valid), .res_val(res_val), .res_flags(res_flags),
        .res_illegal(res_illegal)
    );

    shl_unit #(.EXT_MODE(1'b0)) dut_basic (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_size(op_size),
        .cnt_from_reg(cnt_from_reg), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
        .src_val(src_val), .cur_flags(cur_flags),
        .res_valid(b_valid), .res_val(b_val), .res_flags(b_flags),
        .res_illegal(b_illegal)
    );

    // Bit-serial reference: shift one position at a time, min(k, w+1) times
    function automatic logic [36:0] model(input int w, input logic [31:0] s, input int k);
        logic [31:0] v;
        logic        c;
        logic        z;
        int          n;
        v = s;
        c = 1'b0;
        n = (k > w + 1) ? w + 1 : k;
        for (int i = 0; i < n; i++) begin
            c = v[w-1];
            for (int j = w - 1; j > 0; j--) v[j] = v[j-1];
            v[0] = 1'b0;
        end
        z = 1'b1;
        for (int j = 0; j < w; j++) if (v[j]) z = 1'b0;
        return {v, 1'b0, v[w-1], z, 1'b0, c};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] sz, input logic from_reg, input logic [4:0] imm,
                         input logic [7:0] rc, input logic [31:0] s, input logic [4:0] cf);
        @(negedge clk);
        op_valid     = 1'b1;
        op_size      = sz;
        cnt_from_reg = from_reg;
        imm_cnt      = imm;
        reg_cnt      = rc;
        src_val      = s;
        cur_flags    = cf;
        @(negedge clk);
        op_valid     = 1'b0;
    endtask

    // Issue a legal op on the extended unit and compare with the model
    task automatic legal_op(input string req, input logic [1:0] sz, input logic from_reg,
                            input int k, input logic [31:0] s, input logic [4:0] cf);
        logic [36:0] e;
        int w;
        w = 8 << sz;
        e = model(w, s, k);
        issue(sz, from_reg, 5'(k), 8'(k), s, cf);
        chk({req, " value"}, 64'(res_val), 64'(e[36:5]));
        chk({req, " flags"}, 64'(res_flags), 64'(e[4:0]));
        chk({req, " legal"}, 64'(res_illegal), 64'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1; op_valid = 1'b0; op_size = 2'd0; cnt_from_reg = 1'b0;
        imm_cnt = '0; reg_cnt = '0; src_val = '0; cur_flags = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset valid", 64'(res_valid), 64'd0);
        chk("R9 reset value", 64'(res_val), 64'd0);
        chk("R9 reset flags", 64'(res_flags), 64'd0);
        chk("R9 reset illegal", 64'(res_illegal), 64'd0);
    endtask

    task automatic t_byte_imm;
        legal_op("R1 R2 R3 byte k1", 2'd0, 1'b0, 1, 32'ha5a5a5a5, 5'b00000);
        chk("R2 byte k1 literal", 64'(res_val), 64'ha5a5a54a);
        chk("R3 byte k1 carry", 64'(res_flags[0]), 64'd1);
        legal_op("R4 byte k2", 2'd0, 1'b0, 2, 32'ha5a5a5a5, 5'b00000);
        chk("R4 byte k2 N", 64'(res_flags[3]), 64'd1);
        legal_op("R2 byte k4", 2'd0, 1'b0, 4, 32'h123456a5, 5'b00000);
        chk("R2 byte k4 literal", 64'(res_val[7:0]), 64'h50);
    endtask

    task automatic t_word_imm;
        legal_op("R2 word k1", 2'd1, 1'b0, 1, 32'ha5a5a5a5, 5'b00000);
        chk("R2 word k1 literal", 64'(res_val), 64'ha5a54b4a);
        legal_op("R3 word k8", 2'd1, 1'b0, 8, 32'ha5a5a5a5, 5'b00000);
        chk("R3 word k8 carry", 64'(res_flags[0]), 64'd1);
        legal_op("R1 word k4", 2'd1, 1'b0, 4, 32'hdeada5a5, 5'b00000);
    endtask

    task automatic t_long_imm;
        legal_op("R2 long k2", 2'd2, 1'b0, 2, 32'ha5a5a5a5, 5'b00000);
        chk("R2 long k2 literal", 64'(res_val), 64'h96969694);
        legal_op("R3 long k16", 2'd2, 1'b0, 16, 32'ha5a5a5a5, 5'b00000);
        chk("R3 long k16 literal", 64'(res_val), 64'ha5a50000);
    endtask

    task automatic t_flags_hv;
        legal_op("R5 hv cleared", 2'd0, 1'b0, 1, 32'h00000081, 5'b11111);
        chk("R5 H", 64'(res_flags[4]), 64'd0);
        chk("R5 V", 64'(res_flags[1]), 64'd0);
        legal_op("R4 zero result", 2'd0, 1'b0, 1, 32'hffffff80, 5'b00000);
        chk("R4 Z set", 64'(res_flags[2]), 64'd1);
    endtask

    task automatic t_reg_count;
        legal_op("R7 word reg5", 2'd1, 1'b1, 5, 32'ha5a5a5a5, 5'b00000);
        chk("R7 word reg5 literal", 64'(res_val), 64'ha5a5b4a0);
        legal_op("R7 long reg5", 2'd2, 1'b1, 5, 32'ha5a5a5a5, 5'b00000);
        chk("R7 long reg5 literal", 64'(res_val), 64'hb4b4b4a0);
        legal_op("R3 reg zero", 2'd1, 1'b1, 0, 32'h0000c001, 5'b00001);
        chk("R3 reg zero C", 64'(res_flags[0]), 64'd0);
        chk("R3 reg zero value", 64'(res_val), 64'h0000c001);
    endtask

    task automatic t_big_counts;
        legal_op("R7 byte eq width", 2'd0, 1'b1, 8, 32'h00000081, 5'b00000);
        chk("R7 byte eq width C", 64'(res_flags[0]), 64'd1);
        chk("R7 byte eq width Z", 64'(res_flags[2]), 64'd1);
        legal_op("R7 byte over width", 2'd0, 1'b1, 9, 32'h000000ff, 5'b00000);
        chk("R7 byte over width C", 64'(res_flags[0]), 64'd0);
        legal_op("R7 long eq width", 2'd2, 1'b1, 32, 32'h00000001, 5'b00000);
        chk("R7 long eq width C", 64'(res_flags[0]), 64'd1);
        legal_op("R7 long 255", 2'd2, 1'b1, 255, 32'hffffffff, 5'b00000);
    endtask

    task automatic t_illegal;
        issue(2'd0, 1'b0, 5'd8, 8'd0, 32'h12345678, 5'b10101);
        chk("R6 byte k8 illegal", 64'(res_illegal), 64'd1);
        chk("R8 byte k8 value", 64'(res_val), 64'h12345678);
        chk("R8 byte k8 flags", 64'(res_flags), 64'b10101);
        issue(2'd1, 1'b0, 5'd16, 8'd0, 32'h0000ffff, 5'b01010);
        chk("R6 word k16 illegal", 64'(res_illegal), 64'd1);
        chk("R8 word k16 flags", 64'(res_flags), 64'b01010);
        issue(2'd2, 1'b0, 5'd3, 8'd0, 32'h1, 5'b00000);
        chk("R6 long k3 illegal", 64'(res_illegal), 64'd1);
        issue(2'd3, 1'b0, 5'd1, 8'd0, 32'hcafef00d, 5'b00100);
        chk("R8 reserved size", 64'({res_illegal, res_val}), {31'd0, 1'b1, 32'hcafef00d});
    endtask

    task automatic t_basic_mode;
        issue(2'd1, 1'b0, 5'd2, 8'd0, 32'ha5a5a5a5, 5'b00000);
        chk("R6 basic k2 legal", 64'(b_illegal), 64'd0);
        chk("R6 basic k2 value", 64'(b_val), 64'ha5a59694);
        issue(2'd2, 1'b0, 5'd4, 8'd0, 32'ha5a5a5a5, 5'b00011);
        chk("R6 basic k4 illegal", 64'(b_illegal), 64'd1);
        chk("R8 basic k4 flags", 64'(b_flags), 64'b00011);
        issue(2'd2, 1'b1, 5'd0, 8'd1, 32'ha5a5a5a5, 5'b00000);
        chk("R7 basic reg count illegal", 64'(b_illegal), 64'd1);
        chk("R7 ext reg count legal", 64'(res_illegal), 64'd0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        chk("R9 idle valid low", 64'(res_valid), 64'd0);
        @(negedge clk);
        op_valid = 1'b1; op_size = 2'd0; cnt_from_reg = 1'b0; imm_cnt = 5'd1;
        src_val = 32'h1; cur_flags = '0;
        chk("R9 not yet valid", 64'(res_valid), 64'd0);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9 valid after one clock", 64'(res_valid), 64'd1);
        @(negedge clk);
        chk("R9 valid drops", 64'(res_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_byte_imm();
        t_word_imm();
        t_long_imm();
        t_flags_hv();
        t_reg_count();
        t_big_counts();
        t_illegal();
        t_basic_mode();
        t_timing();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule